// File: doc/BRIEF.md
# Block-Enabled One-Hot Ring Counter

This block is a one-hot ring counter of `WIDTH` bits. A single set bit steps one place toward the most significant end each cycle that `advance` is high, and wraps from the top bit back to bit 0. The counter is cut into equal segments of `BLK` flip-flops, and each segment has its own update enable. Only the segment that holds the set bit, plus a neighbour during a hand-over, has its enable high. The other segments keep their all-zero contents, which matches what a shift would have left there. A design that needs a cheap rotating phase select can use this block, because most of the counter flops are left idle on every cycle.

Each segment has a small controller with two named states. `CTL_IDLE` means disarmed: the controller watches only its entry signal. `CTL_ARMED` means armed: it watches only its leave signal. The entry signal is the serial input of the segment, which is the top bit of the segment below it (the last segment, for segment 0). The leave signal is the lowest bit of the segment above it (segment 0, for the last segment). The transition `arm` (IDLE to ARMED) is taken on any clock edge where entry is high. The transition `disarm` (ARMED to IDLE) is taken on any clock edge where leave is high. The enable output is high in ARMED, and in IDLE it follows entry, so a segment is already enabled on the edge that moves the bit into it. The controller has the same four inputs whatever the segment size. Reset is synchronous.

Top module: `hot_ring_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is `count` = 1 (only bit 0 set) and `block_active` = 1 (only segment 0 enabled). Segment 0's controller starts in ARMED and all other controllers start in IDLE.
- R2: Outside reset, exactly one bit of `count` is 1.
- R3: At an edge with `advance` high, the set bit moves from position p to position (p+1) mod `WIDTH`. The bit at `WIDTH`-1 therefore wraps to bit 0.
- R4: At an edge with `advance` low, `count` does not change.
- R5: Segment h covers bits h*`BLK` to h*`BLK`+`BLK`-1 and drives `block_active[h]`. The segment holding the set bit always has its `block_active` bit high.
- R6: Let the set bit be at offset o within segment h, and let M = `WIDTH`/`BLK`. Then `block_active` is exactly the set made of: h; segment (h+1) mod M when o = `BLK`-1; and segment (h-1) mod M when the last edge was an advancing edge that moved the bit to o = 0. With `BLK` of 2 or more, no more than two bits are ever set.
- R7: A segment whose `block_active` bit is low at a clock edge keeps its bits unchanged across that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Step the set bit one place when high |
| count | output | WIDTH | One-hot counter value |
| block_active | output | WIDTH/BLK | Update enable of each segment |

## Verification
The bench first holds `advance` low, which separates a counter that holds its value from one that drifts. It then advances on every cycle for several full turns, which exposes wrap errors and stale enables left behind when the bit crosses a segment. Next it advances on alternate cycles, so the bit sits for one idle cycle at each segment edge. This tells early arming (entry seen without a move) apart from the lingering enable that a segment keeps for one cycle after its bit leaves. A long seeded random run and a reset in the middle of counting complete the patterns.

// File: rtl/ring_pkg.sv
package ring_pkg;

    // States of one segment's enable controller
    typedef enum logic {
        CTL_IDLE  = 1'b0,
        CTL_ARMED = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/ring_block_ctl.sv
module ring_block_ctl
    import ring_pkg::*;
#(
    parameter bit ARMED_AT_RESET = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic entrance,  // set bit reaches this segment on the next step
    input  logic leave,     // set bit now sits in the segment above
    output logic enable
);

    ctl_state_e state_q;
    ctl_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARMED_AT_RESET ? CTL_ARMED : CTL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state: idle watches entrance only, armed watches leave only
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_IDLE:  if (entrance) state_d = CTL_ARMED;
            CTL_ARMED: if (leave)    state_d = CTL_IDLE;
            default:   state_d = CTL_IDLE;
        endcase
    end

    // Output: already enabled in the cycle the bit is about to enter
    always_comb begin
        unique case (state_q)
            CTL_IDLE:  enable = entrance;
            CTL_ARMED: enable = 1'b1;
            default:   enable = 1'b0;
        endcase
    end

endmodule

// File: rtl/ring_segment.sv
module ring_segment #(
    parameter int BLK          = 4,
    parameter bit HOT_AT_RESET = 1'b0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift,
    input  logic           ser_in,
    output logic [BLK-1:0] q
);

    localparam logic [BLK-1:0] HOT_PAT  = BLK'(1);
    localparam logic [BLK-1:0] RST_PAT  = HOT_AT_RESET ? HOT_PAT : '0;

    logic [BLK-1:0] q_next;

    generate
        if (BLK == 1) begin : g_single
            assign q_next = ser_in;
        end else begin : g_multi
            assign q_next = {q[BLK-2:0], ser_in};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_PAT;
        end else if (shift) begin
            q <= q_next;
        end
    end

endmodule

// File: rtl/hot_ring_counter.sv
module hot_ring_counter #(
    parameter int  WIDTH = 16,
    parameter int  BLK   = 4,
    localparam int NBLK  = WIDTH / BLK
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [WIDTH-1:0] count,
    output logic [NBLK-1:0]  block_active
);

    generate
        if ((WIDTH % BLK) != 0 || NBLK < 2 || WIDTH < 3) begin : g_bad_cfg
            $error("hot_ring_counter: WIDTH must be a multiple of BLK, with at least two segments and three bits");
        end
    endgenerate

    generate
        for (genvar b = 0; b < NBLK; b++) begin : g_seg
            localparam int LO       = b * BLK;
            localparam int PREV_TOP = ((b + NBLK - 1) % NBLK) * BLK + BLK - 1;
            localparam int NEXT_LO  = ((b + 1) % NBLK) * BLK;

            logic           seg_en;
            logic [BLK-1:0] seg_q;

            ring_block_ctl #(
                .ARMED_AT_RESET(b == 0)
            ) u_ctl (
                .clk      (clk),
                .rst      (rst),
                .entrance (count[PREV_TOP]),
                .leave    (count[NEXT_LO]),
                .enable   (seg_en)
            );

            ring_segment #(
                .BLK          (BLK),
                .HOT_AT_RESET (b == 0)
            ) u_seg (
                .clk    (clk),
                .rst    (rst),
                .shift  (seg_en & advance),
                .ser_in (count[PREV_TOP]),
                .q      (seg_q)
            );

            assign count[LO +: BLK] = seg_q;
            assign block_active[b]  = seg_en;
        end
    endgenerate

endmodule

// File: rtl/hot_ring_counter_checker.sv
module hot_ring_counter_checker #(
    parameter int  WIDTH = 16,
    parameter int  BLK   = 4,
    localparam int NBLK  = WIDTH / BLK
) (
    input logic             clk,
    input logic             rst,
    input logic             advance,
    input logic [WIDTH-1:0] count,
    input logic [NBLK-1:0]  block_active
);

    localparam logic [WIDTH-1:0] RST_CNT = WIDTH'(1);
    localparam logic [NBLK-1:0]  RST_ACT = NBLK'(1);
    localparam int               MAX_ACT = (BLK == 1) ? 3 : 2;

    assert_reset_value_R1: assert property (@(posedge clk)
        rst |=> (count == RST_CNT && block_active == RST_ACT));

    assert_one_hot_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(count) == 1);

    assert_step_up_R3: assert property (@(posedge clk) disable iff (rst)
        advance |=> (count == {$past(count[WIDTH-2:0]), $past(count[WIDTH-1])}));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(count));

    assert_enable_bound_R6: assert property (@(posedge clk) disable iff (rst)
        ($countones(block_active) >= 1) && ($countones(block_active) <= MAX_ACT));

    generate
        for (genvar b = 0; b < NBLK; b++) begin : g_chk
            assert_hot_enabled_R5: assert property (@(posedge clk) disable iff (rst)
                (count[b*BLK +: BLK] != '0) |-> block_active[b]);

            assert_idle_frozen_R7: assert property (@(posedge clk) disable iff (rst)
                !block_active[b] |=> $stable(count[b*BLK +: BLK]));
        end
    endgenerate

endmodule

bind hot_ring_counter hot_ring_counter_checker #(
    .WIDTH (WIDTH),
    .BLK   (BLK)
) u_checker (
    .clk          (clk),
    .rst          (rst),
    .advance      (advance),
    .count        (count),
    .block_active (block_active)
);

// File: tb/hot_ring_counter_test.sv
module hot_ring_counter_test;

    localparam int W = 16;
    localparam int K = 4;
    localparam int M = W / K;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         advance = 1'b0;
    logic [W-1:0] count;
    logic [M-1:0] block_active;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    int           pos = 0;      // model: position of the set bit
    bit           just_in = 0;  // model: last edge moved the bit to offset 0
    logic [W-1:0] prev_cnt;
    logic [M-1:0] prev_act;

    always #4 clk = ~clk;  // 125 MHz

    hot_ring_counter #(.WIDTH(W), .BLK(K)) uut (
        .clk          (clk),
        .rst          (rst),
        .advance      (advance),
        .count        (count),
        .block_active (block_active)
    );

    function automatic logic [W-1:0] exp_count(input int p);
        logic [W-1:0] v = '0;
        v[p] = 1'b1;
        return v;
    endfunction

    function automatic logic [M-1:0] exp_active(input int p, input bit ji);
        logic [M-1:0] v = '0;
        int h = p / K;
        int o = p % K;
        v[h] = 1'b1;
        if (o == K - 1) v[(h + 1) % M] = 1'b1;
        if (ji)         v[(h + M - 1) % M] = 1'b1;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (pos=%0d)", tag, act, exp, pos);
        end
    endtask

    task automatic check_all(input bit moved, input bit adv);
        chk("R2 single set bit", 64'($countones(count)), 64'd1);
        if (adv) chk("R3 step/wrap", 64'(count), 64'(exp_count(pos)));
        else     chk("R4 hold",      64'(count), 64'(exp_count(pos)));
        chk("R5 hot segment enabled", 64'(block_active[pos / K]), 64'd1);
        chk("R6 enable set", 64'(block_active), 64'(exp_active(pos, just_in)));
        if (moved) begin
            for (int b = 0; b < M; b++) begin
                if (!prev_act[b])
                    chk("R7 idle segment frozen", 64'(count[b*K +: K]), 64'(prev_cnt[b*K +: K]));
            end
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, check at the next falling edge
    task automatic step(input bit adv);
        prev_cnt = count;
        prev_act = block_active;
        advance  = adv;
        @(negedge clk);
        if (adv) begin
            pos     = (pos + 1) % W;
            just_in = (pos % K == 0);
        end else begin
            just_in = 0;
        end
        check_all(1'b1, adv);
    endtask

    task automatic do_reset();
        rst     = 1'b1;
        advance = 1'b0;
        @(negedge clk);
        @(negedge clk);
        pos     = 0;
        just_in = 0;
        chk("R1 reset count",  64'(count),        64'(exp_count(0)));
        chk("R1 reset enable", 64'(block_active), 64'(1));
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_1234);
        @(negedge clk);
        do_reset();

        // R4: hold with advance low
        repeat (5) step(1'b0);

        // R3: continuous stepping, three full turns through the wrap
        repeat (3 * W) step(1'b1);

        // R6: alternate cycles so the bit pauses at each segment edge
        repeat (2 * W) begin
            step(1'b1);
            step(1'b0);
        end

        // R6: stop exactly at a top offset and at a bottom offset for several cycles
        while ((pos % K) != K - 1) step(1'b1);
        repeat (3) step(1'b0);
        step(1'b1);
        repeat (3) step(1'b0);

        // seeded random mix
        repeat (400) step(($urandom() % 10) < 6);

        // R1: reset during counting
        while (pos == 0) step(1'b1);
        do_reset();
        repeat (2 * W) step(1'b1);

        finish_run();
    end

endmodule